// File: doc/BRIEF.md
# NAND Page Write Formatter

This block orders the bytes of one NAND page on the write side. A host streams in sector data with each sector's ECC bytes right after its data. The block sends the bytes out in flash column order, and each output byte carries its column index. The geometry is set by parameters: four 512-byte sectors, each followed by 14 ECC bytes, a 2048-byte main area and a 64-byte spare area. With these values the fourth sector runs 56 bytes past the main area into the spare area.

A group of bytes at the start of the spare area is protected. This is where a factory bad-block marker lives. An erased byte reads 0xFF, and any other value there marks the block as bad. The spilled part of the last sector is moved up by a configured even skip count, so that it lands after the protected group. What goes into the protected group depends on the transfer mode:
- **Main-only mode:** the group is filled with a configured marker byte.
- **Main+spare mode:** the group is filled with bytes that the host supplies.
- **Spare-only mode:** the skip count and the marker are ignored, and the block writes just the spare area, taking bytes straight from the input.

The block checks its configuration when a page starts. It refuses a start whose settings cannot fit in the spare area.

Top module: `nand_page_fmt`

## Requirements
- R1: After reset `busy`, `out_valid`, `in_ready` and `cfg_err` are all 0.
- R2: In main-only and main+spare modes a page is emitted as columns 0 to 2111, each exactly once and in increasing order. `out_last` is 1 only on column 2111.
- R3: In main-only mode (`cfg_mode` = 0), the layout is as follows, and only the host bytes are taken from the input:
  - Input bytes fill columns 0 to 2047.
  - Columns 2048 to 2048+skip-1 carry `cfg_marker`.
  - The remaining 56 input bytes fill columns 2048+skip onward.
  - Every later column up to 2111 carries 0xFF.
- R4: In main+spare mode (`cfg_mode` = 2), columns 0 to 2048+skip+55 are all taken from the input in order, and the rest of the page is 0xFF. The host therefore supplies the protected bytes at columns 2048 to 2048+skip-1.
- R5: In spare-only mode (`cfg_mode` = 1), columns 2048 to 2111 are emitted straight from 64 input bytes. The skip count and the marker have no effect in this mode, and an odd skip is accepted.
- R6: A start in an idle state is rejected in these cases:
  - `cfg_mode` is 3.
  - In modes 0 or 2, the skip is odd.
  - In modes 0 or 2, skip+56 exceeds 64.

  A rejected start sets `cfg_err` to 1, leaves `busy` at 0 and emits no byte. The next accepted start clears `cfg_err`.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_col` and `out_last` stay unchanged and `out_valid` stays 1. No byte is lost or repeated under back-pressure on either side.
- R8: With a skip of 0 in main-only mode, the spilled bytes start at column 2048 and no marker byte appears.
- R9: A `start` pulse while `busy` is 1 has no effect on the page in progress or on `cfg_err`.
- R10: `in_ready` is 1 only while busy and when the column being built takes a host byte. The block consumes no input for marker or pad columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page with the current configuration |
| cfg_mode | input | 2 | Transfer mode: 0 main-only, 1 spare-only, 2 main+spare, 3 reserved |
| cfg_skip | input | 8 | Number of protected bytes at the base of the spare area |
| cfg_marker | input | 8 | Byte written to the protected bytes in main-only mode |
| busy | output | 1 | A page is being sequenced |
| cfg_err | output | 1 | Last start was rejected |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_col | output | 12 | Column index of the output byte |
| out_last | output | 1 | Output byte is the last column of the page |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The hardest case is the column where the block switches from host bytes to generated marker or pad bytes while both handshakes are stalling. At that point a wrong `in_ready` would quietly take one input byte too many and shift the rest of the page. The stimulus drives both valid and ready with periodic gaps of different lengths, so stalls land on many different columns, including the boundaries at 2048, 2048+skip and the end of the spill. Every page is compared byte by byte with an image computed from the mode, skip, marker and an input pattern. The number of input bytes consumed is also checked against the count the mode requires.

// File: rtl/nand_fmt_pkg.sv
package nand_fmt_pkg;

    typedef enum logic [1:0] {
        MODE_MAIN  = 2'd0,
        MODE_SPARE = 2'd1,
        MODE_BOTH  = 2'd2,
        MODE_RSVD  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SRC_HOST = 2'd0,
        SRC_MARK = 2'd1,
        SRC_PAD  = 2'd2
    } byte_src_e;

endpackage

// File: rtl/nand_cfg_check.sv
module nand_cfg_check
    import nand_fmt_pkg::*;
#(
    parameter int SKIP_W      = 8,
    parameter int SPILL_BYTES = 56,
    parameter int SPARE_BYTES = 64
) (
    input  xfer_mode_e         mode,
    input  logic [SKIP_W-1:0]  skip,
    output logic               cfg_ok
);
    localparam logic [31:0] SPILL32 = 32'(SPILL_BYTES);
    localparam logic [31:0] SPARE32 = 32'(SPARE_BYTES);

    logic [31:0] skip_ext;
    logic        fits;

    assign skip_ext = {{(32-SKIP_W){1'b0}}, skip};

    generate
        if (SPILL_BYTES > SPARE_BYTES) begin : g_never_fits
            assign fits = 1'b0;
        end else begin : g_fit_cmp
            assign fits = (skip_ext + SPILL32) <= SPARE32;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_SPARE: cfg_ok = 1'b1;
            MODE_MAIN,
            MODE_BOTH:  cfg_ok = fits && !skip[0];
            default:    cfg_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/nand_col_map.sv
module nand_col_map
    import nand_fmt_pkg::*;
#(
    parameter int COL_W       = 12,
    parameter int SKIP_W      = 8,
    parameter int MAIN_BYTES  = 2048,
    parameter int SPILL_BYTES = 56
) (
    input  logic [COL_W-1:0]  col,
    input  xfer_mode_e        mode,
    input  logic [SKIP_W-1:0] skip,
    output byte_src_e         src
);
    localparam logic [COL_W-1:0] MAIN_COL  = COL_W'(MAIN_BYTES);
    localparam logic [COL_W-1:0] SPILL_COL = COL_W'(SPILL_BYTES);

    logic [COL_W-1:0] gap_end;
    logic [COL_W-1:0] spill_end;

    assign gap_end   = MAIN_COL + {{(COL_W-SKIP_W){1'b0}}, skip};
    assign spill_end = gap_end + SPILL_COL;

    always_comb begin
        src = SRC_HOST;
        if (mode != MODE_SPARE) begin
            if (col < MAIN_COL) begin
                src = SRC_HOST;
            end else if (col < gap_end) begin
                src = (mode == MODE_MAIN) ? SRC_MARK : SRC_HOST;
            end else if (col < spill_end) begin
                src = SRC_HOST;
            end else begin
                src = SRC_PAD;
            end
        end
    end

endmodule

// File: rtl/nand_page_fmt.sv
module nand_page_fmt
    import nand_fmt_pkg::*;
#(
    parameter int          SECTOR_BYTES = 512,
    parameter int          ECC_BYTES    = 14,
    parameter int          SECTORS      = 4,
    parameter int          MAIN_BYTES   = 2048,
    parameter int          SPARE_BYTES  = 64,
    parameter int          COL_W        = 12,
    parameter int          SKIP_W       = 8,
    parameter logic [7:0]  PAD_BYTE     = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [SKIP_W-1:0] cfg_skip,
    input  logic [7:0]        cfg_marker,
    output logic              busy,
    output logic              cfg_err,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic [COL_W-1:0]  out_col,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int SPILL_BYTES = SECTORS * (SECTOR_BYTES + ECC_BYTES) - MAIN_BYTES;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam logic [COL_W-1:0] MAIN_COL = COL_W'(MAIN_BYTES);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    typedef struct packed {
        logic              active;
        xfer_mode_e        mode;
        logic [SKIP_W-1:0] skip;
        logic [7:0]        marker;
        logic [COL_W-1:0]  col;
        logic              err;
        logic              ovalid;
        logic [7:0]        odata;
        logic [COL_W-1:0]  ocol;
        logic              olast;
    } fmt_state_t;

    fmt_state_t st_d, st_q;

    xfer_mode_e req_mode;
    logic       req_ok;
    byte_src_e  cur_src;
    logic       slot_free;

    assign req_mode = xfer_mode_e'(cfg_mode);

    nand_cfg_check #(
        .SKIP_W      (SKIP_W),
        .SPILL_BYTES (SPILL_BYTES),
        .SPARE_BYTES (SPARE_BYTES)
    ) cfg_chk_i (
        .mode   (req_mode),
        .skip   (cfg_skip),
        .cfg_ok (req_ok)
    );

    nand_col_map #(
        .COL_W       (COL_W),
        .SKIP_W      (SKIP_W),
        .MAIN_BYTES  (MAIN_BYTES),
        .SPILL_BYTES (SPILL_BYTES)
    ) col_map_i (
        .col  (st_q.col),
        .mode (st_q.mode),
        .skip (st_q.skip),
        .src  (cur_src)
    );

    assign slot_free = !st_q.ovalid || out_ready;

    always_comb begin
        st_d = st_q;

        if (st_q.ovalid && out_ready) begin
            st_d.ovalid = 1'b0;
        end

        if (st_q.active && slot_free) begin
            if (cur_src != SRC_HOST || in_valid) begin
                st_d.ovalid = 1'b1;
                st_d.ocol   = st_q.col;
                st_d.olast  = (st_q.col == LAST_COL);
                unique case (cur_src)
                    SRC_MARK: st_d.odata = st_q.marker;
                    SRC_PAD:  st_d.odata = PAD_BYTE;
                    default:  st_d.odata = in_data;
                endcase
                if (st_q.col == LAST_COL) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.col = st_q.col + 1'b1;
                end
            end
        end

        if (!st_q.active && start) begin
            if (req_ok) begin
                st_d.active = 1'b1;
                st_d.mode   = req_mode;
                st_d.skip   = cfg_skip;
                st_d.marker = cfg_marker;
                st_d.col    = (req_mode == MODE_SPARE) ? MAIN_COL : '0;
                st_d.err    = 1'b0;
            end else begin
                st_d.err    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, mode: MODE_MAIN, skip: '0, marker: 8'hFF,
                      col: '0, err: 1'b0, ovalid: 1'b0, odata: '0,
                      ocol: '0, olast: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.active && slot_free && (cur_src == SRC_HOST);
    assign busy      = st_q.active;
    assign cfg_err   = st_q.err;
    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.odata;
    assign out_col   = st_q.ocol;
    assign out_last  = st_q.olast;

endmodule

// File: rtl/nand_page_fmt_chk.sv
module nand_page_fmt_chk
    import nand_fmt_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int SKIP_W     = 8,
    parameter int MAIN_BYTES = 2048,
    parameter int PAGE_BYTES = 2112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        cfg_mode,
    input logic              busy,
    input logic              cfg_err,
    input logic              in_ready,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic [COL_W-1:0]  out_col,
    input logic              out_last,
    input logic              out_ready,
    input xfer_mode_e        cur_mode,
    input logic [SKIP_W-1:0] cur_skip,
    input logic [7:0]        cur_marker
);
    localparam logic [COL_W-1:0] MAIN_COL = COL_W'(MAIN_BYTES);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    logic [COL_W-1:0] gap_end;
    assign gap_end = MAIN_COL + {{(COL_W-SKIP_W){1'b0}}, cur_skip};

    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_col) && $stable(out_last)));

    a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (!out_valid || out_col == $past(out_col) + 1'b1));

    a_r2_last_col: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_col == LAST_COL));

    a_r6_reject_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cfg_mode == 2'd3) |=> (cfg_err && !busy));

    a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    a_r3_marker_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cur_mode == MODE_MAIN && out_col >= MAIN_COL && out_col < gap_end)
            |-> (out_data == cur_marker));

    a_r5_spare_cols: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cur_mode == MODE_SPARE) |-> (out_col >= MAIN_COL));

endmodule

bind nand_page_fmt nand_page_fmt_chk #(
    .COL_W      (COL_W),
    .SKIP_W     (SKIP_W),
    .MAIN_BYTES (MAIN_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_mode   (cfg_mode),
    .busy       (busy),
    .cfg_err    (cfg_err),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_col    (out_col),
    .out_last   (out_last),
    .out_ready  (out_ready),
    .cur_mode   (st_q.mode),
    .cur_skip   (st_q.skip),
    .cur_marker (st_q.marker)
);

// File: tb/nand_page_fmt_tb_top.sv
module nand_page_fmt_tb_top;

    localparam int MAIN  = 2048;
    localparam int SPILL = 56;
    localparam int LAST  = 2111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [7:0]  cfg_skip = 8'd0;
    logic [7:0]  cfg_marker = 8'hFF;
    logic        busy, cfg_err, in_ready, out_valid, out_last;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [11:0] out_col;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    nand_page_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_skip(cfg_skip), .cfg_marker(cfg_marker), .busy(busy),
        .cfg_err(cfg_err), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_col(out_col), .out_last(out_last), .out_ready(out_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 13 + seed * 7 + (i >> 8)) & 255);
    endfunction

    // expected byte for a column: mode 0 main, 1 spare, 2 main+spare
    function automatic logic [7:0] exp_byte(input int mode, input int skip,
                                            input int mark, input int seed, input int col);
        if (mode == 1) return pat(col - MAIN, seed);
        if (col < MAIN) return pat(col, seed);
        if (mode == 0) begin
            if (col < MAIN + skip) return 8'(mark);
            if (col < MAIN + skip + SPILL) return pat(col - skip, seed);
            return 8'hFF;
        end
        if (col < MAIN + skip + SPILL) return pat(col, seed);
        return 8'hFF;
    endfunction

    task automatic run_page(input int mode, input int skip, input int mark,
                            input int seed, input bit poke_busy, input string req);
        int in_idx = 0;
        int exp_col = (mode == 1) ? MAIN : 0;
        int exp_in = (mode == 1) ? 64 : (mode == 0 ? MAIN + SPILL : MAIN + SPILL + skip);
        bit done = 0;
        bit stalled = 0;
        logic [7:0]  s_data = '0;
        logic [11:0] s_col = '0;
        logic        s_last = 1'b0;
        int k = 0;
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_skip = 8'(skip); cfg_marker = 8'(mark);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R6 err cleared on good start"}, int'(cfg_err), 0);
        while (!done && k < 12000) begin
            if (k > 0) @(negedge clk);
            start = 1'b0;
            if (poke_busy && k == 300) begin
                cfg_mode = 2'd3; cfg_skip = 8'd5; cfg_marker = 8'h00;
                start = 1'b1;
            end
            out_ready = ((k % 5) != 3);
            in_valid  = ((k % 7) != 2);
            in_data   = pat(in_idx, seed);
            #1;
            if (stalled) begin
                chk({req, " R7 stall hold"}, int'({out_valid, out_data, out_col, out_last}),
                    int'({1'b1, s_data, s_col, s_last}));
            end
            stalled = out_valid && !out_ready;
            s_data = out_data; s_col = out_col; s_last = out_last;
            if (out_valid && out_ready) begin
                chk({req, " R2 col"}, int'(out_col), exp_col);
                chk({req, " R3/R4/R5 data"}, int'(out_data),
                    int'(exp_byte(mode, skip, mark, seed, exp_col)));
                chk({req, " R2 last"}, int'(out_last), int'(exp_col == LAST));
                if (out_last) done = 1;
                exp_col++;
            end
            if (in_valid && in_ready) in_idx++;
            k++;
        end
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        chk({req, " R2 page completed"}, int'(done), 1);
        chk({req, " R10 input bytes consumed"}, in_idx, exp_in);
        if (poke_busy) chk({req, " R9 cfg_err untouched"}, int'(cfg_err), 0);
    endtask

    task automatic try_bad(input int mode, input int skip, input string req);
        bit seen = 0;
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_skip = 8'(skip); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R6 cfg_err"}, int'(cfg_err), 1);
        chk({req, " R6 not busy"}, int'(busy), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid || in_ready) seen = 1;
        end
        chk({req, " R6 no activity"}, int'(seen), 0);
    endtask

    // vector: mode, skip, marker, seed
    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] skip;
        logic [7:0] mark;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 8'd2, 8'hFF, 8'd11},   // R3
        '{2'd0, 8'd0, 8'hA5, 8'd22},   // R8
        '{2'd2, 8'd2, 8'h00, 8'd33},   // R4
        '{2'd2, 8'd8, 8'h5A, 8'd44},   // R4 max skip
        '{2'd1, 8'd3, 8'h77, 8'd55},   // R5 odd skip ignored
        '{2'd0, 8'd8, 8'h00, 8'd66},   // R3 max skip
        '{2'd1, 8'd0, 8'hFF, 8'd77}    // R5
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);

        for (int v = 0; v < 7; v++) begin
            run_page(int'(VECS[v].mode), int'(VECS[v].skip), int'(VECS[v].mark),
                     int'(VECS[v].seed), 1'b0, $sformatf("vec%0d", v));
        end

        try_bad(0, 3, "odd skip");
        try_bad(2, 10, "skip too large");
        try_bad(3, 2, "reserved mode");
        run_page(0, 4, 8'h3C, 91, 1'b1, "R9 start while busy");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule